// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block gives boot firmware a byte-wide I/O view of which CPUs are present. The presence bitmap has one bit for each CPU. A bit's position in the bitmap is that CPU's local interrupt-controller ID, so byte `id/8`, bit `id%8` belongs to CPU `id`. The platform reports a hot-added CPU on a request port. The block then sets that CPU's bit and, while it is in legacy mode, latches a general-purpose event status bit. That bit, gated by its enable bit, drives a level interrupt to the firmware event handler. Bits are never cleared by a remove, because removal is not supported.

The bitmap is read-only to ordinary writes. There is one exception. Firmware that understands the newer per-CPU hotplug register interface writes zero into each of the four bytes of the first bitmap DWORD. After the last of those four zero writes, the block raises `new_mode_o`. That output stays high until reset. From then on, hot-add requests still record presence but no longer raise the legacy event.

The I/O address has one more bit than the bitmap needs. When that top bit is clear, the access goes to the bitmap. When it is set, the access goes to a small event block: offset 0 holds the status byte and offset 1 holds the enable byte, with only bit 2 implemented in each. A read strobe returns its byte on `io_rdata_o` in the following cycle.

Top module: `cpu_presence_port`

## Requirements
- R1: After a synchronous reset, every presence bit, the event status and enable bits, `sci_o`, `new_mode_o` and `io_rdata_o` are 0.
- R2: A hot-add request with ID `id` sets bitmap byte `id/8`, bit `id%8`. A read issued in any later cycle returns it set.
- R3: Writes to bitmap bytes never change the bitmap contents.
- R4: In legacy mode a hot-add request sets event status bit 2 (event block offset 0). The bit stays set until it is cleared.
- R5: A write to event offset 0 with data bit 2 set clears the status bit. If bit 2 of the data is clear, the write has no effect. A hot-add in the same cycle as a clear leaves the bit set.
- R6: `sci_o` equals status bit 2 AND enable bit 2 (enable at event offset 1). It changes at the same clock edge that updates either bit.
- R7: `new_mode_o` rises at the edge of the last of four zero writes covering bitmap bytes 0, 1, 2 and 3, in any order. Non-zero writes to those bytes, and zero writes to bytes 4 and above, do not count towards the switch.
- R8: Once `new_mode_o` is 1 it stays 1 until reset. In new mode a hot-add still sets the presence bit but does not set the status bit.
- R9: Read data appears on `io_rdata_o` in the cycle after `io_rd_i`. Event offset 0 reads `8'h04` when status is set, offset 1 reads `8'h04` when enable is set, and all other event offsets read 0.
- R10: No input other than reset clears a presence bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| io_addr_i | input | AW+1 | Byte address; top bit selects the event block, the rest index the byte |
| io_wr_i | input | 1 | Write strobe, one byte per cycle |
| io_wdata_i | input | 8 | Write data |
| io_rd_i | input | 1 | Read strobe |
| io_rdata_o | output | 8 | Read data, registered, valid the cycle after the read strobe |
| add_valid_i | input | 1 | Hot-add request |
| add_id_i | input | ID_W | CPU ID of the hot-added CPU |
| sci_o | output | 1 | Event interrupt level |
| new_mode_o | output | 1 | High once the block has left legacy mode |

## Verification
The assertions assume the following about the inputs:
- A hot-add ID is below the CPU count.
- Strobes carry known values at every clock edge.
- An address whose top bit is clear always names an existing bitmap byte.

The bench uses a 64-CPU configuration, which is a power of two, so every ID and every bitmap offset it can drive is legal. Its stimulus keeps read and write strobes in separate cycles and changes inputs only on the falling edge. Zero writes to the first DWORD are issued only in the phase that tests the mode switch.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;
  // Bit position of the CPU hotplug event inside the status and enable bytes.
  localparam int EVT_BIT      = 2;
  // Offsets inside the event block.
  localparam int EVT_STS_OFS  = 0;
  localparam int EVT_EN_OFS   = 1;
  // Number of leading bitmap bytes that must be written with zero to switch.
  localparam int SWITCH_BYTES = 4;

  // Decoded access for one cycle.
  typedef struct packed {
    logic bmp_wr;
    logic sts_wr;
    logic en_wr;
    logic evt_rd;
  } io_dec_t;
endpackage

// File: rtl/presence_bitmap.sv
module presence_bitmap #(
  parameter int NUM_CPUS = 256,
  localparam int BYTES   = NUM_CPUS / 8,
  localparam int AW      = $clog2(BYTES),
  localparam int ID_W    = $clog2(NUM_CPUS)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                set_i,
  input  logic [ID_W-1:0]     set_id_i,
  input  logic [AW-1:0]       rd_idx_i,
  output logic [7:0]          rd_byte_o,
  output logic [NUM_CPUS-1:0] bits_o
);
  logic [NUM_CPUS-1:0] bits_q;
  logic [7:0]          byte_view [BYTES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bits_q <= '0;
    end else if (set_i && (int'(set_id_i) < NUM_CPUS)) begin
      bits_q[set_id_i] <= 1'b1;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign byte_view[g] = bits_q[g*8 +: 8];
  end

  assign rd_byte_o = byte_view[rd_idx_i];
  assign bits_o    = bits_q;
endmodule

// File: rtl/mode_latch.sv
module mode_latch #(
  parameter int AW           = 5,
  parameter int SWITCH_BYTES = cpu_presence_pkg::SWITCH_BYTES,
  localparam int SW          = $clog2(SWITCH_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  output logic          new_mode_o
);
  logic [SWITCH_BYTES-1:0] seen_q, seen_d;
  logic                    mode_q;

  always_comb begin
    seen_d = seen_q;
    if (wr_i && (int'(wr_idx_i) < SWITCH_BYTES) && (wr_data_i == 8'h00)) begin
      seen_d[wr_idx_i[SW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen_q <= '0;
      mode_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      if (&seen_d) mode_q <= 1'b1;
    end
  end

  assign new_mode_o = mode_q;
endmodule

// File: rtl/event_block.sv
module event_block (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       raise_i,
  input  logic       sts_wr_i,
  input  logic       en_wr_i,
  input  logic [7:0] wdata_i,
  output logic       sts_o,
  output logic       en_o,
  output logic       irq_o
);
  import cpu_presence_pkg::*;

  logic sts_q, en_q, irq_q;
  logic sts_d, en_d;

  always_comb begin
    sts_d = sts_q;
    if (sts_wr_i && wdata_i[EVT_BIT]) sts_d = 1'b0;
    if (raise_i) sts_d = 1'b1;
    en_d = en_wr_i ? wdata_i[EVT_BIT] : en_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sts_q <= 1'b0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
      irq_q <= sts_d & en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cpu_presence_port.sv
module cpu_presence_port #(
  parameter int NUM_CPUS = 256,
  localparam int BYTES   = NUM_CPUS / 8,
  localparam int AW      = $clog2(BYTES),
  localparam int ID_W    = $clog2(NUM_CPUS)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [AW:0]     io_addr_i,
  input  logic            io_wr_i,
  input  logic [7:0]      io_wdata_i,
  input  logic            io_rd_i,
  output logic [7:0]      io_rdata_o,
  input  logic            add_valid_i,
  input  logic [ID_W-1:0] add_id_i,
  output logic            sci_o,
  output logic            new_mode_o
);
  import cpu_presence_pkg::*;

  io_dec_t             dec;
  logic [AW-1:0]       ofs;
  logic [7:0]          bmp_byte;
  logic [7:0]          evt_byte;
  logic [NUM_CPUS-1:0] bits_w;
  logic                evt_sts_w, evt_en_w;
  logic [7:0]          rdata_q;

  assign ofs = io_addr_i[AW-1:0];

  always_comb begin
    dec        = '0;
    dec.bmp_wr = io_wr_i && !io_addr_i[AW];
    dec.sts_wr = io_wr_i && io_addr_i[AW] && (ofs == AW'(EVT_STS_OFS));
    dec.en_wr  = io_wr_i && io_addr_i[AW] && (ofs == AW'(EVT_EN_OFS));
    dec.evt_rd = io_addr_i[AW];
  end

  presence_bitmap #(.NUM_CPUS(NUM_CPUS)) bmp_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .set_i     (add_valid_i),
    .set_id_i  (add_id_i),
    .rd_idx_i  (ofs),
    .rd_byte_o (bmp_byte),
    .bits_o    (bits_w)
  );

  mode_latch #(.AW(AW)) mode_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_i       (dec.bmp_wr),
    .wr_idx_i   (ofs),
    .wr_data_i  (io_wdata_i),
    .new_mode_o (new_mode_o)
  );

  event_block evt_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .raise_i  (add_valid_i && !new_mode_o),
    .sts_wr_i (dec.sts_wr),
    .en_wr_i  (dec.en_wr),
    .wdata_i  (io_wdata_i),
    .sts_o    (evt_sts_w),
    .en_o     (evt_en_w),
    .irq_o    (sci_o)
  );

  always_comb begin
    evt_byte = '0;
    if (ofs == AW'(EVT_STS_OFS)) evt_byte[EVT_BIT] = evt_sts_w;
    if (ofs == AW'(EVT_EN_OFS))  evt_byte[EVT_BIT] = evt_en_w;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else if (io_rd_i) begin
      rdata_q <= dec.evt_rd ? evt_byte : bmp_byte;
    end
  end

  assign io_rdata_o = rdata_q;
endmodule

// File: rtl/cpu_presence_chk.sv
module cpu_presence_chk #(
  parameter int NUM_CPUS = 256,
  localparam int BYTES   = NUM_CPUS / 8,
  localparam int AW      = $clog2(BYTES),
  localparam int ID_W    = $clog2(NUM_CPUS)
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [AW:0]         io_addr_i,
  input logic                io_wr_i,
  input logic [7:0]          io_wdata_i,
  input logic                add_valid_i,
  input logic [ID_W-1:0]     add_id_i,
  input logic [NUM_CPUS-1:0] presence,
  input logic                evt_sts,
  input logic                evt_en,
  input logic                sci_o,
  input logic                new_mode_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!sci_o && !new_mode_o && !evt_sts && presence == '0)); // R1

  AST_HOTADD_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    add_valid_i |=> presence[$past(add_id_i)]); // R2

  AST_BITS_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ((~presence & $past(presence)) == '0)); // R10

  AST_LEGACY_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
    (add_valid_i && !new_mode_o) |=> evt_sts); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    sci_o |-> (evt_en && evt_sts)); // R6

  AST_SWITCH_ON_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(new_mode_o) |-> $past(io_wr_i && !io_addr_i[AW] &&
                                (int'(io_addr_i[AW-1:0]) < cpu_presence_pkg::SWITCH_BYTES) &&
                                io_wdata_i == 8'h00)); // R7

  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    new_mode_o |=> new_mode_o); // R8
endmodule

bind cpu_presence_port cpu_presence_chk #(.NUM_CPUS(NUM_CPUS)) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .io_addr_i   (io_addr_i),
  .io_wr_i     (io_wr_i),
  .io_wdata_i  (io_wdata_i),
  .add_valid_i (add_valid_i),
  .add_id_i    (add_id_i),
  .presence    (bits_w),
  .evt_sts     (evt_sts_w),
  .evt_en      (evt_en_w),
  .sci_o       (sci_o),
  .new_mode_o  (new_mode_o)
);

// File: tb/cpu_presence_port_tb_top.sv
module cpu_presence_port_tb_top;
  localparam int NCPU  = 64;
  localparam int BYTES = NCPU / 8;
  localparam int AW    = $clog2(BYTES);
  localparam int ID_W  = $clog2(NCPU);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW:0]     io_addr = '0;
  logic            io_wr = 1'b0;
  logic [7:0]      io_wdata = '0;
  logic            io_rd = 1'b0;
  logic [7:0]      io_rdata;
  logic            add_valid = 1'b0;
  logic [ID_W-1:0] add_id = '0;
  logic            sci, new_mode;

  int total = 0;
  int bad   = 0;
  logic [NCPU-1:0] model;

  always #2.5 clk = ~clk;

  cpu_presence_port #(.NUM_CPUS(NCPU)) dut_i (
    .clk_i(clk), .rst_i(rst), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_wdata_i(io_wdata), .io_rd_i(io_rd), .io_rdata_o(io_rdata),
    .add_valid_i(add_valid), .add_id_i(add_id), .sci_o(sci), .new_mode_o(new_mode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    step();
    io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    step();
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic hot_add(input int id);
    add_valid = 1'b1; add_id = ID_W'(id);
    step();
    add_valid = 1'b0;
  endtask

  task automatic check_bitmap(input string tag);
    logic [7:0] d;
    for (int b = 0; b < BYTES; b++) begin
      do_read({1'b0, AW'(b)}, d);
      check(d == model[b*8 +: 8], tag, d, model[b*8 +: 8]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    model = '0;
  endtask

  localparam logic [AW:0] EVT_STS = {1'b1, AW'(0)};
  localparam logic [AW:0] EVT_EN  = {1'b1, AW'(1)};

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check(sci == 1'b0, "R1 sci", sci, 0);
    check(new_mode == 1'b0, "R1 new_mode", new_mode, 0);
    check(io_rdata == 8'h00, "R1 rdata", io_rdata, 0);
    check_bitmap("R1 bitmap");
    do_read(EVT_STS, d); check(d == 8'h00, "R1 status", d, 0);
    do_read(EVT_EN, d);  check(d == 8'h00, "R1 enable", d, 0);

    // R9: enable reads bit 2 only, unused event offsets read 0
    do_write(EVT_EN, 8'hFF);
    do_read(EVT_EN, d); check(d == 8'h04, "R9 enable byte", d, 8'h04);
    for (int o = 2; o < BYTES; o++) begin
      do_read({1'b1, AW'(o)}, d);
      check(d == 8'h00, "R9 unused event offset", d, 0);
    end

    // R2 R4 R6 R5: sweep every CPU ID in a scrambled order
    for (int k = 0; k < NCPU; k++) begin
      int id;
      id = (k * 29) % NCPU;
      hot_add(id);
      model[id] = 1'b1;
      check(sci == 1'b1, "R6 irq after hot-add", sci, 1);
      do_read(EVT_STS, d); check(d == 8'h04, "R4 status set", d, 8'h04);
      do_read({1'b0, AW'(id / 8)}, d);
      check(d == model[(id/8)*8 +: 8], "R2 byte after hot-add", d, model[(id/8)*8 +: 8]);
      do_write(EVT_STS, 8'h04);
      check(sci == 1'b0, "R5 irq after clear", sci, 0);
      if (k % 16 == 15) check_bitmap("R2 full bitmap");
      // R3: non-zero writes leave bitmap unchanged
      if (k == 20) begin
        for (int b = 0; b < BYTES; b++) do_write({1'b0, AW'(b)}, 8'hA5 ^ 8'(b));
        for (int b = 4; b < BYTES; b++) do_write({1'b0, AW'(b)}, 8'h00);
        check_bitmap("R3 after writes");
        check(new_mode == 1'b0, "R7 no switch from upper zeros", new_mode, 0);
      end
    end

    // R5: write 0 does not clear, set wins over clear
    hot_add(3);
    do_write(EVT_STS, 8'hFB);
    do_read(EVT_STS, d); check(d == 8'h04, "R5 zero bit keeps status", d, 8'h04);
    do_write(EVT_STS, 8'h04);
    io_addr = EVT_STS; io_wdata = 8'h04; io_wr = 1'b1; add_valid = 1'b1; add_id = ID_W'(5);
    step();
    io_wr = 1'b0; add_valid = 1'b0;
    do_read(EVT_STS, d); check(d == 8'h04, "R5 set wins over clear", d, 8'h04);

    // R6: enable gating
    do_write(EVT_EN, 8'h00);
    check(sci == 1'b0, "R6 irq masked", sci, 0);
    do_write(EVT_EN, 8'h04);
    check(sci == 1'b1, "R6 irq unmasked", sci, 1);

    // R10: all bits remain set
    check_bitmap("R10 bits persist");

    // R7 R8: mode switch
    do_reset();
    check(new_mode == 1'b0, "R1 legacy after reset", new_mode, 0);
    do_write({1'b0, AW'(2)}, 8'h00);
    do_write({1'b0, AW'(0)}, 8'h00);
    do_write({1'b0, AW'(3)}, 8'h00);
    check(new_mode == 1'b0, "R7 three zeros", new_mode, 0);
    do_write({1'b0, AW'(1)}, 8'h10);
    do_write({1'b0, AW'(5)}, 8'h00);
    check(new_mode == 1'b0, "R7 non-zero ignored", new_mode, 0);
    do_write({1'b0, AW'(1)}, 8'h00);
    check(new_mode == 1'b1, "R7 switch on last zero", new_mode, 1);
    do_write(EVT_EN, 8'h04);
    hot_add(9);
    model[9] = 1'b1;
    check(sci == 1'b0, "R8 no irq in new mode", sci, 0);
    do_read(EVT_STS, d); check(d == 8'h00, "R8 no status in new mode", d, 0);
    do_read({1'b0, AW'(1)}, d); check(d == 8'h02, "R8 presence in new mode", d, 8'h02);
    for (int b = 0; b < BYTES; b++) do_write({1'b0, AW'(b)}, 8'hFF);
    check(new_mode == 1'b1, "R8 sticky", new_mode, 1);
    check_bitmap("R3 bitmap in new mode");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule